// File: doc/BRIEF.md
# Receive FIFO Flow-Control Controller

This block watches how full a receive data FIFO is and decides when the link partner should be told to hold off. In full-duplex operation it asks the transmitter for one pause frame carrying a programmed pause time when the FIFO fill reaches a high mark. After that pause has gone out, it asks for a pause frame with a zero time once the fill drops below a lower mark, so the partner resumes sending. The gap between the two marks keeps the controller from toggling on small changes in fill.

In half-duplex operation no pause frames are used. Instead, each incoming frame whose start is signalled while the FIFO sits at or above the high mark is jammed with back pressure, if its address class is enabled. The back pressure lasts for a coded number of cycles. A 32-bit configuration word holds both marks, the duration code and the class enables. Pause requests use a valid/ready handshake toward the transmit path. The block is silent whenever the transmitter is disabled.

Top module: `rxfc_ctrl`

## Requirements
- R1: While and directly after reset, `pause_req` and `back_press` are 0 and `pause_value` is 0.
- R2: In full duplex with `tx_enable` high and any of config bits 3:0 set, the block is idle. A clock edge at which `fifo_level` >= (config bits 23:16)×64 raises `pause_req` in the next cycle, with `pause_value` equal to `pause_time` sampled at that edge. The request stays high until an edge with `pause_ready` and `tx_enable` both high.
- R3: Once the high-mark pause has been accepted, no further request is made while the fill stays at or above the low mark, whatever the fill does above it.
- R4: After an accepted high-mark pause in full duplex, an edge with `fifo_level` < (config bits 15:8)×64 raises `pause_req` in the next cycle with `pause_value` = 0. The request is held until it is accepted. A fill between the two marks causes no request.
- R5: With no high-mark pause outstanding, a fill below the low mark never produces a request.
- R6: While `tx_enable` is 0, `pause_req` and `back_press` are 0. A pending request is kept, and it reappears when `tx_enable` returns.
- R7: In half duplex with `tx_enable` high, a `sof` edge raises `back_press` from the next cycle for exactly (code+1)×16 cycles, where code is config bits 7:4. Two conditions must hold at that edge: the fill is at or above the high mark, and the frame matches an enabled class. The classes are: bit 0 any frame, bit 1 own-address, bit 2 broadcast, bit 3 multicast. A new matching start reloads the count.
- R8: A frame that matches no enabled class, or that starts below the high mark, produces no back pressure.
- R9: In full duplex, `back_press` stays 0 whatever the duration code and class bits are. In half duplex, an idle controller issues no pause request.
- R10: While a request waits for `pause_ready`, `pause_value` does not change, even if `pause_time` does.
- R11: With config bits 3:0 all zero, an idle controller issues no pause request at any fill level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_word | input | 32 | Marks, duration code and class enables |
| fifo_level | input | LEVEL_W | Receive FIFO fill in bytes |
| full_duplex | input | 1 | 1 = full duplex, 0 = half duplex |
| tx_enable | input | 1 | Transmitter enabled |
| pause_time | input | PT_W | Pause time for the high-mark frame |
| sof | input | 1 | Start-of-frame strobe for a received frame |
| sof_mcast | input | 1 | Frame is multicast (valid with sof) |
| sof_bcast | input | 1 | Frame is broadcast (valid with sof) |
| sof_own | input | 1 | Frame is addressed to this station (valid with sof) |
| pause_ready | input | 1 | Transmitter accepts the pending pause request |
| pause_req | output | 1 | Pause frame requested |
| pause_value | output | PT_W | Pause time to send with the request |
| back_press | output | 1 | Jam the current half-duplex frame |

## Verification
The controller's memory is whether a high-mark pause is outstanding. A lost or spurious flag therefore appears at the ports in one of two ways. It can show as a repeated high-mark request while the fill stays high. It can also show as a missing or unprompted zero-time request, one cycle after the fill crosses the low mark. A wrong jam counter shows as a back-pressure pulse of the wrong length, so the bench measures every pulse to the cycle. A reference model updated on the same edges compares all three outputs on every clock, so any divergence is reported within the cycle it appears.

// File: rtl/rxfc_pkg.sv
package rxfc_pkg;

    localparam int CFG_W      = 32;
    localparam int MARK_W     = 8;
    localparam int CODE_W     = 4;

    // Configuration word; field positions are fixed by software.
    typedef struct packed {
        logic [7:0]        rsvd;
        logic [MARK_W-1:0] hi_units;
        logic [MARK_W-1:0] lo_units;
        logic [CODE_W-1:0] dur_code;
        logic              on_mcast;
        logic              on_bcast;
        logic              on_own;
        logic              on_any;
    } rxfc_cfg_t;

    typedef struct packed {
        logic mcast;
        logic bcast;
        logic own;
    } frame_cls_t;

    typedef enum logic [1:0] {
        PS_IDLE    = 2'd0,
        PS_HI_PEND = 2'd1,
        PS_ARMED   = 2'd2,
        PS_LO_PEND = 2'd3
    } pause_st_e;

    function automatic logic afc_enabled(rxfc_cfg_t c);
        return c.on_any | c.on_own | c.on_bcast | c.on_mcast;
    endfunction

    function automatic logic class_hit(rxfc_cfg_t c, frame_cls_t f);
        return c.on_any | (c.on_own & f.own) | (c.on_bcast & f.bcast)
             | (c.on_mcast & f.mcast);
    endfunction

endpackage

// File: rtl/rxfc_thresh.sv
module rxfc_thresh #(
    parameter int LEVEL_W    = 16,
    parameter int MARK_W     = 8,
    parameter int UNIT_SHIFT = 6
) (
    input  logic [LEVEL_W-1:0] fifo_level,
    input  logic [MARK_W-1:0]  hi_units,
    input  logic [MARK_W-1:0]  lo_units,
    output logic               at_high,
    output logic               under_low
);
    localparam int BYTE_W = MARK_W + UNIT_SHIFT;
    localparam int CMP_W  = (LEVEL_W > BYTE_W) ? LEVEL_W : BYTE_W;

    logic [CMP_W-1:0] lvl_x, hi_x, lo_x;

    always_comb begin
        lvl_x = CMP_W'(fifo_level);
        hi_x  = CMP_W'({hi_units, {UNIT_SHIFT{1'b0}}});
        lo_x  = CMP_W'({lo_units, {UNIT_SHIFT{1'b0}}});
        at_high   = (lvl_x >= hi_x);
        under_low = (lvl_x <  lo_x);
    end
endmodule

// File: rtl/rxfc_pause_fsm.sv
module rxfc_pause_fsm
    import rxfc_pkg::*;
#(
    parameter int PT_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            afc_en,
    input  logic            full_duplex,
    input  logic            tx_enable,
    input  logic            at_high,
    input  logic            under_low,
    input  logic [PT_W-1:0] pause_time,
    input  logic            pause_ready,
    output logic            pause_req,
    output logic [PT_W-1:0] pause_value
);
    pause_st_e       st_q;
    logic [PT_W-1:0] val_q;
    logic            pending;
    logic            accepted;

    assign pending  = (st_q == PS_HI_PEND) || (st_q == PS_LO_PEND);
    assign accepted = pause_ready && tx_enable;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= PS_IDLE;
            val_q <= '0;
        end else begin
            unique case (st_q)
                PS_IDLE: begin
                    if (afc_en && full_duplex && tx_enable && at_high) begin
                        st_q  <= PS_HI_PEND;
                        val_q <= pause_time;
                    end
                end
                PS_HI_PEND: begin
                    if (accepted) st_q <= PS_ARMED;
                end
                PS_ARMED: begin
                    if (full_duplex && under_low) begin
                        st_q  <= PS_LO_PEND;
                        val_q <= '0;
                    end
                end
                PS_LO_PEND: begin
                    if (accepted) st_q <= PS_IDLE;
                end
                default: st_q <= PS_IDLE;
            endcase
        end
    end

    assign pause_req   = pending && tx_enable;
    assign pause_value = val_q;
endmodule

// File: rtl/rxfc_jam.sv
module rxfc_jam #(
    parameter int CODE_W     = 4,
    parameter int STEP_SHIFT = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hd_active,
    input  logic              trigger,
    input  logic [CODE_W-1:0] dur_code,
    output logic              back_press
);
    localparam int CNT_W = CODE_W + STEP_SHIFT + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] load_val;

    assign load_val = (CNT_W'(dur_code) + CNT_W'(1)) << STEP_SHIFT;

    always_ff @(posedge clk) begin
        if (rst || !hd_active) begin
            cnt_q <= '0;
        end else if (trigger) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign back_press = (cnt_q != '0) && hd_active;
endmodule

// File: rtl/rxfc_ctrl.sv
module rxfc_ctrl
    import rxfc_pkg::*;
#(
    parameter int LEVEL_W    = 16,
    parameter int PT_W       = 16,
    parameter int UNIT_SHIFT = 6,
    parameter int STEP_SHIFT = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [31:0]        cfg_word,
    input  logic [LEVEL_W-1:0] fifo_level,
    input  logic               full_duplex,
    input  logic               tx_enable,
    input  logic [PT_W-1:0]    pause_time,
    input  logic               sof,
    input  logic               sof_mcast,
    input  logic               sof_bcast,
    input  logic               sof_own,
    input  logic               pause_ready,
    output logic               pause_req,
    output logic [PT_W-1:0]    pause_value,
    output logic               back_press
);
    rxfc_cfg_t  cfg;
    frame_cls_t fcls;
    logic       at_high, under_low, afc_en, hd_active, jam_trig;

    assign cfg       = rxfc_cfg_t'(cfg_word);
    assign fcls      = '{mcast: sof_mcast, bcast: sof_bcast, own: sof_own};
    assign afc_en    = afc_enabled(cfg);
    assign hd_active = !full_duplex && tx_enable;
    assign jam_trig  = sof && at_high && class_hit(cfg, fcls);

    rxfc_thresh #(
        .LEVEL_W(LEVEL_W), .MARK_W(MARK_W), .UNIT_SHIFT(UNIT_SHIFT)
    ) u_thresh (
        .fifo_level(fifo_level), .hi_units(cfg.hi_units),
        .lo_units(cfg.lo_units), .at_high(at_high), .under_low(under_low)
    );

    rxfc_pause_fsm #(.PT_W(PT_W)) u_pause (
        .clk(clk), .rst(rst), .afc_en(afc_en), .full_duplex(full_duplex),
        .tx_enable(tx_enable), .at_high(at_high), .under_low(under_low),
        .pause_time(pause_time), .pause_ready(pause_ready),
        .pause_req(pause_req), .pause_value(pause_value)
    );

    rxfc_jam #(.CODE_W(CODE_W), .STEP_SHIFT(STEP_SHIFT)) u_jam (
        .clk(clk), .rst(rst), .hd_active(hd_active), .trigger(jam_trig),
        .dur_code(cfg.dur_code), .back_press(back_press)
    );
endmodule

// File: rtl/rxfc_chk.sv
module rxfc_chk #(
    parameter int LEVEL_W    = 16,
    parameter int PT_W       = 16,
    parameter int UNIT_SHIFT = 6
) (
    input logic               clk,
    input logic               rst,
    input logic [31:0]        cfg_word,
    input logic [LEVEL_W-1:0] fifo_level,
    input logic               full_duplex,
    input logic               tx_enable,
    input logic               sof,
    input logic               sof_mcast,
    input logic               sof_bcast,
    input logic               sof_own,
    input logic               pause_ready,
    input logic               pause_req,
    input logic [PT_W-1:0]    pause_value,
    input logic               back_press
);
    logic jam_due;
    assign jam_due = sof && !full_duplex && tx_enable
        && (int'(fifo_level) >= (int'(cfg_word[23:16]) << UNIT_SHIFT))
        && (cfg_word[0] || (cfg_word[1] && sof_own)
            || (cfg_word[2] && sof_bcast) || (cfg_word[3] && sof_mcast));

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!pause_req && !back_press && pause_value == '0)); // R1

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (pause_req && !pause_ready) |=> (pause_req || !tx_enable)); // R2

    AST_TX_SILENT: assert property (@(posedge clk) disable iff (rst)
        !tx_enable |-> (!pause_req && !back_press)); // R6

    AST_JAM_START: assert property (@(posedge clk) disable iff (rst)
        jam_due |=> (back_press || !tx_enable || full_duplex)); // R7

    AST_FD_NO_JAM: assert property (@(posedge clk) disable iff (rst)
        full_duplex |-> !back_press); // R9

    AST_VALUE_STABLE: assert property (@(posedge clk) disable iff (rst)
        (pause_req && !pause_ready) |=> $stable(pause_value)); // R10
endmodule

bind rxfc_ctrl rxfc_chk #(
    .LEVEL_W(LEVEL_W), .PT_W(PT_W), .UNIT_SHIFT(UNIT_SHIFT)
) u_chk (
    .clk(clk), .rst(rst), .cfg_word(cfg_word), .fifo_level(fifo_level),
    .full_duplex(full_duplex), .tx_enable(tx_enable), .sof(sof),
    .sof_mcast(sof_mcast), .sof_bcast(sof_bcast), .sof_own(sof_own),
    .pause_ready(pause_ready), .pause_req(pause_req),
    .pause_value(pause_value), .back_press(back_press)
);

// File: tb/sim_rxfc_ctrl.sv
`timescale 1ns/1ps
module sim_rxfc_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] cfg_word = '0;
    logic [15:0] fifo_level = '0;
    logic        full_duplex = 1'b0, tx_enable = 1'b0;
    logic [15:0] pause_time = '0;
    logic        sof = 0, sof_mcast = 0, sof_bcast = 0, sof_own = 0;
    logic        pause_ready = 1'b0;
    logic        pause_req, back_press;
    logic [15:0] pause_value;

    int checks = 0, errors = 0, cyc = 0;
    bit done = 0;

    always #5 clk = ~clk;

    rxfc_ctrl u0 (
        .clk(clk), .rst(rst), .cfg_word(cfg_word), .fifo_level(fifo_level),
        .full_duplex(full_duplex), .tx_enable(tx_enable),
        .pause_time(pause_time), .sof(sof), .sof_mcast(sof_mcast),
        .sof_bcast(sof_bcast), .sof_own(sof_own), .pause_ready(pause_ready),
        .pause_req(pause_req), .pause_value(pause_value),
        .back_press(back_press)
    );

    // Behavioural reference: outstanding-pause phase, latched value, jam length
    int m_phase = 0;   // 0 none, 1 high wanted, 2 high sent, 3 resume wanted
    int m_val = 0;
    int m_left = 0;

    always @(posedge clk) begin
        int hi_b, lo_b, lvl;
        bit en, match;
        cyc++;
        hi_b = int'(cfg_word[23:16]) * 64;
        lo_b = int'(cfg_word[15:8]) * 64;
        lvl  = int'(fifo_level);
        en   = cfg_word[3:0] != 0;
        match = cfg_word[0] || (cfg_word[1] && sof_own)
             || (cfg_word[2] && sof_bcast) || (cfg_word[3] && sof_mcast);
        if (rst) begin
            m_phase = 0; m_val = 0; m_left = 0;
        end else begin
            if (m_phase == 0 && en && full_duplex && tx_enable && lvl >= hi_b) begin
                m_phase = 1; m_val = int'(pause_time);
            end else if (m_phase == 1 && pause_ready && tx_enable) m_phase = 2;
            else if (m_phase == 2 && full_duplex && lvl < lo_b) begin
                m_phase = 3; m_val = 0;
            end else if (m_phase == 3 && pause_ready && tx_enable) m_phase = 0;
            if (full_duplex || !tx_enable) m_left = 0;
            else if (sof && match && lvl >= hi_b)
                m_left = (int'(cfg_word[7:4]) + 1) * 16;
            else if (m_left > 0) m_left--;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) if (!done) begin
        int e_req, e_bp;
        e_req = ((m_phase == 1 || m_phase == 3) && tx_enable) ? 1 : 0;
        e_bp  = (m_left > 0 && tx_enable && !full_duplex) ? 1 : 0;
        chk(int'(pause_req) == e_req, "R2 model pause_req", int'(pause_req), e_req);
        if (e_req == 1)
            chk(int'(pause_value) == m_val, "R10 model pause_value", int'(pause_value), m_val);
        chk(int'(back_press) == e_bp, "R7 model back_press", int'(back_press), e_bp);
        if (cyc > 20000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic tick(input int n = 1);
        repeat (n) @(posedge clk);
        #1;
    endtask

    function automatic logic [31:0] mk(input int hi, input int lo, input int code, input int en);
        return {8'h00, 8'(hi), 8'(lo), 4'(code), 4'(en)};
    endfunction

    task automatic jam_len(input int exp, input string tag);
        int n = 0;
        while (back_press && n < 1000) begin n++; tick(); end
        chk(n == exp, tag, n, exp);
    endtask

    initial begin
        tick(3);
        chk(!pause_req && !back_press && pause_value == 0, "R1 reset outputs",
            int'(pause_req) + int'(back_press), 0);
        rst = 0;
        full_duplex = 1; tx_enable = 1; cfg_word = mk(4, 2, 0, 4'b0001);
        pause_time = 16'h1234; fifo_level = 100;
        tick(2);
        chk(!pause_req, "R2 below high mark", int'(pause_req), 0);
        fifo_level = 256; tick();
        chk(pause_req && pause_value == 16'h1234, "R2 high mark request",
            int'(pause_value), 16'h1234);
        fifo_level = 300; pause_time = 16'h5555; tick(2);
        chk(pause_req && pause_value == 16'h1234, "R10 value held", int'(pause_value), 16'h1234);
        pause_ready = 1; tick(); pause_ready = 0;
        chk(!pause_req, "R3 accepted", int'(pause_req), 0);
        tick(5);
        chk(!pause_req, "R3 no repeat above high", int'(pause_req), 0);
        fifo_level = 150; tick(3);
        chk(!pause_req, "R4 between marks", int'(pause_req), 0);
        fifo_level = 127; tick();
        chk(pause_req && pause_value == 0, "R4 zero-time request", int'(pause_value), 0);
        tick(2);
        chk(pause_req, "R4 resume held", int'(pause_req), 1);
        pause_ready = 1; tick(); pause_ready = 0;
        fifo_level = 50; tick(4);
        chk(!pause_req, "R5 no resume without pause", int'(pause_req), 0);
        cfg_word = mk(4, 2, 0, 0); fifo_level = 400; tick(3);
        chk(!pause_req, "R11 afc disabled", int'(pause_req), 0);
        cfg_word = mk(4, 2, 0, 4'b0100); tick();
        chk(pause_req && pause_value == 16'h5555, "R2 request after enable",
            int'(pause_value), 16'h5555);
        tx_enable = 0; tick();
        chk(!pause_req, "R6 tx off masks request", int'(pause_req), 0);
        pause_ready = 1; tick(); pause_ready = 0;
        tx_enable = 1; #1;
        chk(pause_req && pause_value == 16'h5555, "R6 pending kept",
            int'(pause_req), 1);
        pause_ready = 1; tick(); pause_ready = 0;
        fifo_level = 50; tick();
        pause_ready = 1; tick(); pause_ready = 0;
        // half duplex
        full_duplex = 0; fifo_level = 400; cfg_word = mk(4, 2, 2, 4'b1000);
        tick(3);
        chk(!pause_req, "R9 no pause in half duplex", int'(pause_req), 0);
        sof = 1; sof_mcast = 1; tick(); sof = 0; sof_mcast = 0;
        jam_len(48, "R7 multicast jam length");
        sof = 1; sof_bcast = 1; tick(); sof = 0; sof_bcast = 0;
        chk(!back_press, "R8 class not enabled", int'(back_press), 0);
        fifo_level = 200; sof = 1; sof_mcast = 1; tick(); sof = 0; sof_mcast = 0;
        chk(!back_press, "R8 below high mark", int'(back_press), 0);
        fifo_level = 400; cfg_word = mk(4, 2, 0, 4'b0010);
        sof = 1; sof_own = 1; tick(); sof = 0; sof_own = 0;
        jam_len(16, "R7 own-address jam length");
        cfg_word = mk(4, 2, 15, 4'b0001);
        sof = 1; tick(); sof = 0;
        chk(back_press, "R7 any-frame jam", int'(back_press), 1);
        tick(10);
        sof = 1; tick(); sof = 0;
        jam_len(256, "R7 retrigger reload");
        sof = 1; tick(); sof = 0; tick(3);
        tx_enable = 0; #1;
        chk(!back_press, "R6 tx off clears jam", int'(back_press), 0);
        tick(); tx_enable = 1; tick();
        chk(!back_press, "R6 jam not resumed", int'(back_press), 0);
        full_duplex = 1; cfg_word = mk(4, 2, 3, 4'b1111);
        sof = 1; sof_mcast = 1; sof_bcast = 1; sof_own = 1; tick();
        sof = 0; sof_mcast = 0; sof_bcast = 0; sof_own = 0;
        chk(!back_press, "R9 no jam in full duplex", int'(back_press), 0);
        tick(4);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule